// File: doc/BRIEF.md
# Programmable periodic interrupt timer

This block is a 32-bit down-counter with a compare interrupt, reached through a small word-indexed register port. Each cycle it takes two clock-enable strobes, a fast peripheral tick and a slow 32 kHz tick. A control field picks one of them, or none. A 12-bit prescaler divides the chosen strobe, and each divided step decrements the counter by one.

When the counter steps down from zero, it either reloads from a programmable load value or wraps to all ones. When a step lands exactly on the compare value, a sticky status flag is set. A level interrupt is raised while that flag, the compare-interrupt enable and the timer enable are all set. Software can also rewrite the live count when it writes the load value. A soft reset restores the data registers and keeps only the operating-mode bits of the control word.

Top module: `pit_timer`

## Requirements
- R1: After reset: control reads 0, status 0, load 0xFFFFFFFF, compare 0, count 0, and `irq` is low.
- R2: Word index 0 is control, 1 is status, 2 is load, 3 is compare and 4 is count (read only). A read of any other index returns 0, and a write to any other index changes nothing.
- R3: A control write stores only bits 25:0. The bit layout is: enable 0, enable-mode 1, compare-interrupt enable 2, reload 3, prescale 15:4, soft reset 16, overwrite 17, debug 18, wait 19, doze 20, stop 21, source 25:24. The soft-reset bit always reads back 0. Bits 18 to 21 are storage only.
- R4: Source 00 gives no steps. Sources 01 and 10 step on `fast_tick`. Source 11 steps on `slow_tick`.
- R5: With prescale value P, the counter steps once every P+1 selected ticks. The tick tally restarts while the timer is disabled.
- R6: A control write that raises enable with enable-mode set loads the count from the load register (reload bit 1) or with 0xFFFFFFFF (reload bit 0). Raising enable with enable-mode clear keeps the held count.
- R7: With reload set, a step from count 0 loads the load value.
- R8: With reload clear, a step from count 0 gives 0xFFFFFFFF.
- R9: A load write while the overwrite bit is set also puts the written value in the count. Without that bit, the count is left alone.
- R10: A step whose new count equals compare, while compare-interrupt enable is set, sets status bit 0. Writing 1 to status bit 0 clears it. Writing 0 does not clear it. A new hit in the same cycle as a clear wins.
- R11: `irq` is high exactly when the status flag, compare-interrupt enable and enable are all 1.
- R12: While enable is 0 the count holds and no compare hit is raised.
- R13: A control write with bit 16 set stores the written value masked to bits 0, 1 and 18 to 21. It clears status, compare and count and sets load to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_tick | input | 1 | Peripheral-rate clock enable |
| slow_tick | input | 1 | 32 kHz clock enable |
| bus_addr | input | AW (4) | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the count through zero in both wrap modes. A design that decremented past zero without reloading, or that reloaded in free-run mode, would show the wrong count right after the wrap. It raises enable with and without enable-mode to tell a restart from a resume. It checks that the prescaler needs exactly P+1 ticks and that an unselected tick source is ignored. A decoder that muddled the source codes would step on the wrong strobe. The bench also lands on compare with the interrupt enable off and with the timer stopped, to expose a flag that fires without being enabled. Finally, it fires a soft reset while the flag is set and the data registers hold non-default values, so a reset that missed a register or kept a stray control bit shows up in the read-back.

// File: rtl/pit_pkg.sv
package pit_pkg;
    // Control word layout
    localparam int CTRL_W   = 26;
    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_CMPIE  = 2;
    localparam int B_RLD    = 3;
    localparam int B_PRE_LO = 4;
    localparam int PRE_W    = 12;
    localparam int B_SWR    = 16;
    localparam int B_OVW    = 17;
    localparam int B_SRC_LO = 24;
    localparam int SRC_W    = 2;
    // Bits kept through a soft reset: enable, enable-mode, debug, wait, doze, stop
    localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h03C_0003;

    typedef enum logic [2:0] {
        IDX_CTRL = 3'd0,
        IDX_STAT = 3'd1,
        IDX_LOAD = 3'd2,
        IDX_CMP  = 3'd3,
        IDX_CNT  = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/pit_regs.sv
// Register file: control, status flag, load and compare.
// Decodes writes and produces the soft-reset, start and overwrite strobes.
// Assumes one write per cycle; the status set takes priority over the clear.
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmp_hit,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              flag_q,
    output logic              sw_rst,
    output logic              start,
    output logic              start_rld,
    output logic              ovw_wr
);
    logic wr_ctrl, wr_stat, wr_load, wr_cmp;

    // Address decode of the write strobe
    always_comb begin
        wr_ctrl   = wr_en && (addr == AW'(IDX_CTRL));
        wr_stat   = wr_en && (addr == AW'(IDX_STAT));
        wr_load   = wr_en && (addr == AW'(IDX_LOAD));
        wr_cmp    = wr_en && (addr == AW'(IDX_CMP));
        sw_rst    = wr_ctrl && wdata[B_SWR];
        start     = wr_ctrl && !wdata[B_SWR] && wdata[B_EN] && wdata[B_ENMOD] && !ctrl_q[B_EN];
        start_rld = wdata[B_RLD];
        ovw_wr    = wr_load && ctrl_q[B_OVW];
    end

    // Register storage with soft reset and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '1;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else if (sw_rst) begin
            ctrl_q <= wdata[CTRL_W-1:0] & KEEP_MASK;
            load_q <= '1;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
            if (wr_load) load_q <= wdata;
            if (wr_cmp)  cmp_q  <= wdata;
            if (cmp_hit)                     flag_q <= 1'b1;
            else if (wr_stat && wdata[0])    flag_q <= 1'b0;
        end
    end

    // R10: the flag only rises after a compare hit
    p_flag_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cmp_hit));

    // R13: soft reset restores the data registers
    p_soft_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (load_q == '1) && (cmp_q == '0) && !flag_q && !ctrl_q[B_SWR]);
endmodule

// File: rtl/pit_prescale.sv
// Tick selection and prescale divider.
// Emits a one-cycle step every (presc+1) selected ticks while enabled.
// Assumes the tick inputs are single-cycle clock enables in the clk domain.
module pit_prescale
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [SRC_W-1:0] src,
    input  logic [PRE_W-1:0] presc,
    input  logic             fast_tick,
    input  logic             slow_tick,
    output logic             step
);
    logic [PRE_W-1:0] tally_q;
    logic             tick_sel;

    // Source select: 00 off, 01/10 fast, 11 slow
    always_comb begin
        case (src)
            2'b00:   tick_sel = 1'b0;
            2'b11:   tick_sel = slow_tick;
            default: tick_sel = fast_tick;
        endcase
        step = en && tick_sel && (tally_q >= presc);
    end

    // Tick tally, restarted while disabled or on soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) tally_q <= '0;
        else if (tick_sel)        tally_q <= step ? '0 : tally_q + 1'b1;
    end

    // R4: a disabled source never steps
    p_src_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'b00) |-> !step);

    // R5: each step restarts the tally
    p_tally_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (tally_q == '0));
endmodule

// File: rtl/pit_count.sv
// Down-counter with reload or free-run wrap and compare detection.
// Priority: soft reset, start, overwrite, step.
// Assumes step is only asserted while the timer is enabled.
module pit_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              start,
    input  logic              start_rld,
    input  logic              ovw,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] load,
    input  logic [DATA_W-1:0] cmp,
    input  logic              rld,
    input  logic              cmpie,
    input  logic              step,
    output logic [DATA_W-1:0] cnt_q,
    output logic              hit
);
    logic [DATA_W-1:0] next_val;
    logic              busy;

    // Next value after a step, and compare hit on that value
    always_comb begin
        if (cnt_q == '0) next_val = rld ? load : '1;
        else             next_val = cnt_q - 1'b1;
        busy = sw_rst || start || ovw;
        hit  = step && !busy && cmpie && (next_val == cmp);
    end

    // Counter update
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) cnt_q <= '0;
        else if (start)       cnt_q <= start_rld ? load : '1;
        else if (ovw)         cnt_q <= wdata;
        else if (step)        cnt_q <= next_val;
    end

    // R12: without a step or a write the count holds
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !busy) |=> $stable(cnt_q));

    // R7: reload wrap
    p_wrap_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !busy && rld && cnt_q == '0) |=> (cnt_q == $past(load)));

    // R8: free-run wrap
    p_wrap_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !busy && !rld && cnt_q == '0) |=> (cnt_q == '1));

    // R6: start value
    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sw_rst) |=> (cnt_q == ($past(start_rld) ? $past(load) : '1)));
endmodule

// File: rtl/pit_timer.sv
// Top level of the periodic interrupt timer: register file, prescaler,
// down-counter, read mux and interrupt gate.
// Assumes a single-cycle write strobe and a combinational read.
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] load_q, cmp_q, cnt_q;
    logic              flag_q, sw_rst, start, start_rld, ovw_wr, step, hit;

    pit_regs #(.DATA_W(DATA_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cmp_hit(hit), .ctrl_q(ctrl_q), .load_q(load_q),
        .cmp_q(cmp_q), .flag_q(flag_q), .sw_rst(sw_rst), .start(start),
        .start_rld(start_rld), .ovw_wr(ovw_wr)
    );

    pit_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_EN]), .clr(sw_rst),
        .src(ctrl_q[B_SRC_LO +: SRC_W]), .presc(ctrl_q[B_PRE_LO +: PRE_W]),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .step(step)
    );

    pit_count #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start(start),
        .start_rld(start_rld), .ovw(ovw_wr), .wdata(bus_wdata),
        .load(load_q), .cmp(cmp_q), .rld(ctrl_q[B_RLD]),
        .cmpie(ctrl_q[B_CMPIE]), .step(step), .cnt_q(cnt_q), .hit(hit)
    );

    // Read mux; unmapped indices read zero
    always_comb begin
        case (bus_addr)
            AW'(IDX_CTRL): bus_rdata = DATA_W'(ctrl_q);
            AW'(IDX_STAT): bus_rdata = DATA_W'(flag_q);
            AW'(IDX_LOAD): bus_rdata = load_q;
            AW'(IDX_CMP):  bus_rdata = cmp_q;
            AW'(IDX_CNT):  bus_rdata = cnt_q;
            default:       bus_rdata = '0;
        endcase
    end

    // Interrupt gate
    assign irq = flag_q && ctrl_q[B_CMPIE] && ctrl_q[B_EN];

    // R12: no compare hit while disabled
    p_no_hit_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[B_EN] |-> !hit);
endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0, slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    pit_timer uut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; #1;
        total++;
        if (bus_rdata !== exp) begin
            bad++;
            $display("FAIL %s idx=%0d actual=%h expected=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        #1; total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    task automatic pulse_fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    task automatic pulse_slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk(0, 32'h0, "R1"); chk(1, 32'h0, "R1"); chk(2, 32'hFFFF_FFFF, "R1");
        chk(3, 32'h0, "R1"); chk(4, 32'h0, "R1"); chk_irq(1'b0, "R1");
    endtask

    task automatic t_decode;
        wr(5, 32'h1234_5678); wr(7, 32'hFFFF_FFFF);
        chk(5, 32'h0, "R2"); chk(7, 32'h0, "R2");
        chk(0, 32'h0, "R2"); chk(2, 32'hFFFF_FFFF, "R2"); chk(3, 32'h0, "R2");
    endtask

    task automatic t_ctrl_mask;
        wr(0, 32'hFCFE_FFF0);
        chk(0, 32'h00FE_FFF0, "R3");
        wr(0, 32'h0);
    endtask

    task automatic t_reload;
        wr(2, 32'd5); wr(3, 32'd2); wr(0, 32'h0100_000F);
        chk(4, 32'd5, "R6");
        pulse_fast(1); chk(4, 32'd4, "R6"); chk(1, 32'd0, "R10");
        pulse_fast(2); chk(4, 32'd2, "R10"); chk(1, 32'd1, "R10"); chk_irq(1'b1, "R11");
        pulse_fast(2); chk(4, 32'd0, "R7");
        pulse_fast(1); chk(4, 32'd5, "R7");
        wr(1, 32'd0); chk(1, 32'd1, "R10");
        wr(1, 32'd1); chk(1, 32'd0, "R10"); chk_irq(1'b0, "R11");
    endtask

    task automatic t_source;
        wr(0, 32'h0); wr(0, 32'h0300_000B);
        chk(4, 32'd5, "R6");
        pulse_fast(3); chk(4, 32'd5, "R4");
        pulse_slow(2); chk(4, 32'd3, "R4");
        wr(0, 32'h0200_000B);
        pulse_fast(1); chk(4, 32'd2, "R4");
        wr(0, 32'h0000_000B);
        pulse_fast(2); pulse_slow(2); chk(4, 32'd2, "R4");
    endtask

    task automatic t_prescale;
        wr(0, 32'h0); wr(0, 32'h0100_003B);
        chk(4, 32'd5, "R5");
        pulse_fast(3); chk(4, 32'd5, "R5");
        pulse_fast(1); chk(4, 32'd4, "R5");
        pulse_fast(4); chk(4, 32'd3, "R5");
    endtask

    task automatic t_hold;
        wr(0, 32'h0100_0008);
        pulse_fast(4); chk(4, 32'd3, "R12"); chk(1, 32'd0, "R12");
        wr(0, 32'h0100_000D); chk(4, 32'd3, "R6");
        pulse_fast(1); chk(4, 32'd2, "R10"); chk(1, 32'd1, "R10"); chk_irq(1'b1, "R11");
        wr(0, 32'h0100_000C); chk_irq(1'b0, "R11"); chk(1, 32'd1, "R11");
        wr(1, 32'd1);
    endtask

    task automatic t_no_cmpie;
        wr(3, 32'd1); wr(0, 32'h0100_0009);
        pulse_fast(1); chk(4, 32'd1, "R10"); chk(1, 32'd0, "R10");
        pulse_fast(2); chk(4, 32'd5, "R7");
    endtask

    task automatic t_overwrite;
        wr(2, 32'd9); chk(4, 32'd5, "R9"); chk(2, 32'd9, "R9");
        wr(0, 32'h0102_0009);
        wr(2, 32'd7); chk(4, 32'd7, "R9");
    endtask

    task automatic t_free;
        wr(0, 32'h0); wr(0, 32'h0102_0003);
        chk(4, 32'hFFFF_FFFF, "R6");
        wr(2, 32'd1); chk(4, 32'd1, "R9");
        pulse_fast(2); chk(4, 32'hFFFF_FFFF, "R8");
        pulse_fast(1); chk(4, 32'hFFFF_FFFE, "R8");
    endtask

    task automatic t_soft_reset;
        wr(3, 32'hFFFF_FFFD); wr(0, 32'h0102_0007);
        pulse_fast(1); chk(1, 32'd1, "R13"); chk_irq(1'b1, "R13");
        wr(0, 32'h03FF_FFFF);
        chk(0, 32'h003C_0003, "R13"); chk(1, 32'd0, "R13");
        chk(2, 32'hFFFF_FFFF, "R13"); chk(3, 32'd0, "R13");
        chk(4, 32'd0, "R13"); chk_irq(1'b0, "R13");
        pulse_fast(2); chk(4, 32'd0, "R13");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_decode;
        t_ctrl_mask;
        t_reload;
        t_source;
        t_prescale;
        t_hold;
        t_no_cmpie;
        t_overwrite;
        t_free;
        t_soft_reset;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule